// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Processor

This block is a small processor built around one 16-bit accumulator. Every instruction word carries a four-bit operation code in its top bits and a twelve-bit direct address below it. The sequencer walks a fixed loop: it fetches the word addressed by the program counter into the instruction register, carries that instruction out, and only then advances the program counter. It repeats the loop until it meets an operation code that stops it.

All memory traffic passes through a memory address register and a memory buffer register. The block drives a synchronous single-port word memory whose read data arrives one clock after the address, so each read phase has its own wait cycle. Load, add and store are the only operations. Opcode zero and every unassigned opcode park the machine in a halted state. The outputs expose the program counter, instruction register and accumulator, together with the halted flag, so a test or a debug view can follow the run.

Top module: `accum_core`

## Requirements
- R1: An instruction word splits into bits 15:12 (operation) and bits 11:0 (direct address). The fetched word appears on `irOut` three cycles after the fetch cycle starts. In the first cycle after the fetch cycle, `memRe` is high and `memAddr` equals the program counter.
- R2: Opcode 4'b0001 loads the addressed word into the accumulator. The new value appears six cycles after the fetch cycle starts.
- R3: Opcode 4'b0010 stores the accumulator. In the fifth cycle of the instruction (four cycles after the fetch cycle), `memWe` is high for exactly one cycle, `memAddr` carries the address field and `memWdata` carries the accumulator.
- R4: Opcode 4'b0101 adds the addressed word to the accumulator modulo 2^16 and raises no flag.
- R5: The program counter stays put while an instruction executes. It increments by one as the last step of each instruction: after 7 cycles for load or add, and after 6 cycles for a store. It wraps from 12'hFFF to 12'h000.
- R6: Opcode 4'b0000 and every opcode other than 0001, 0010 and 0101 set `halted` four cycles after the fetch cycle starts. While halted, `memRe` and `memWe` stay low, and the program counter (left at the stopping instruction) and the accumulator hold their values.
- R7: While the synchronous active-high reset is high, the block clears the accumulator and instruction register, loads the program counter from `startAddr`, keeps `halted` low and makes no memory access. The first cycle after reset is a fetch cycle.
- R8: With 0x1940, 0x5941 and 0x2941 at 0x300 to 0x302, and 3 and 2 at 0x940 and 0x941, a run from 0x300 steps the program counter through 0x300, 0x301, 0x302 and 0x303, and leaves 5 in the accumulator and 5 at 0x941.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| startAddr | input | 12 | Program counter value loaded during reset |
| memRdata | input | 16 | Read data, valid one cycle after a read request |
| memAddr | output | 12 | Memory address, driven from the address register |
| memWdata | output | 16 | Write data, driven from the buffer register |
| memRe | output | 1 | Read request for the current address |
| memWe | output | 1 | Write strobe for the current address |
| halted | output | 1 | High once a stopping opcode has executed |
| pcOut | output | 12 | Current program counter |
| accOut | output | 16 | Current accumulator |
| irOut | output | 16 | Current instruction register |

## Verification
Each result falls due a fixed number of clock edges after the fetch cycle of its instruction starts:

| Result | Edges after fetch start |
|--------|-------------------------|
| Read request on the program counter | 1 |
| Instruction register | 3 |
| Store strobe | 4 |
| Halted flag | 4 |
| Stored word visible in memory | 5 |
| Accumulator | 6 |
| Program counter (store) | 6 |
| Program counter (load, add) | 7 |

The bench releases reset on a falling edge and advances whole cycles from one falling edge to the next. It samples each output right after the edge on which that output is due. It also checks the cycle just before each program counter step, to show the counter has not moved early.

// File: rtl/accum_pkg.sv
package accum_pkg;
  parameter int DATA_W = 16;
  parameter int OP_W   = 4;
  localparam int ADDR_W = DATA_W - OP_W;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_STORE = 4'b0010;
  localparam logic [OP_W-1:0] OP_ADD   = 4'b0101;

  typedef enum logic [3:0] {
    PH_FETCH, PH_FWAIT, PH_DECODE, PH_EXEC,
    PH_EREAD, PH_EALU, PH_EWRITE, PH_INCR, PH_HALT
  } phase_t;

  typedef struct packed {
    logic marFromPc;
    logic marFromRd;
    logic irLoad;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic accLoad;
    logic accAdd;
    logic pcInc;
    logic memRe;
    logic memWe;
  } strobes_t;
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output strobes_t        st,
  output logic            halted
);
  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phaseNext;
  end

  always_comb begin
    st        = '0;
    phaseNext = phase;
    case (phase)
      PH_FETCH:  begin st.marFromPc = 1'b1; phaseNext = PH_FWAIT; end
      PH_FWAIT:  begin st.memRe = 1'b1; phaseNext = PH_DECODE; end
      PH_DECODE: begin st.irLoad = 1'b1; st.marFromRd = 1'b1; phaseNext = PH_EXEC; end
      PH_EXEC: begin
        case (opcode)
          OP_LOAD, OP_ADD: begin st.memRe = 1'b1; phaseNext = PH_EREAD; end
          OP_STORE:        begin st.mbrFromAcc = 1'b1; phaseNext = PH_EWRITE; end
          default:         phaseNext = PH_HALT;
        endcase
      end
      PH_EREAD:  begin st.mbrFromMem = 1'b1; phaseNext = PH_EALU; end
      PH_EALU: begin
        if (opcode == OP_ADD) st.accAdd = 1'b1;
        else                  st.accLoad = 1'b1;
        phaseNext = PH_INCR;
      end
      PH_EWRITE: begin st.memWe = 1'b1; phaseNext = PH_INCR; end
      PH_INCR:   begin st.pcInc = 1'b1; phaseNext = PH_FETCH; end
      PH_HALT:   phaseNext = PH_HALT;
      default:   phaseNext = PH_HALT;
    endcase
  end

  assign halted = (phase == PH_HALT);

  // R6: the halted state issues no memory traffic
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!st.memRe && !st.memWe));

  // R6: halting is permanent until reset
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R3: a write strobe lasts a single cycle
  p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
    st.memWe |=> !st.memWe);

  // R1: read and write never coincide
  p_rw_excl_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.memRe, st.memWe}));
endmodule

// File: rtl/accum_dpath.sv
module accum_dpath
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] startAddr,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ir,
  output logic [OP_W-1:0]   opcode
);
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] sum;

  assign sum = acc + mbr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= startAddr;
      ir  <= '0;
      acc <= '0;
      mar <= '0;
      mbr <= '0;
    end else begin
      if (st.marFromPc)      mar <= pc;
      else if (st.marFromRd) mar <= memRdata[ADDR_W-1:0];

      if (st.irLoad) begin
        ir  <= memRdata;
        mbr <= memRdata;
      end else if (st.mbrFromMem) begin
        mbr <= memRdata;
      end else if (st.mbrFromAcc) begin
        mbr <= acc;
      end

      if (st.accLoad)     acc <= mbr;
      else if (st.accAdd) acc <= sum;

      if (st.pcInc) pc <= pc + 1'b1;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign opcode   = ir[DATA_W-1:ADDR_W];

  // R5: the program counter only ever moves forward by one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));

  // R2: the accumulator only changes on an ALU strobe
  p_acc_guard_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc != $past(acc)) |-> $past(st.accLoad || st.accAdd));

  // R3: a write carries the accumulator to the instruction's address
  p_store_data_r3: assert property (@(posedge clk) disable iff (rst)
    st.memWe |-> (memWdata == acc && memAddr == ir[ADDR_W-1:0]));
endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRe,
  output logic              memWe,
  output logic              halted,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] irOut
);
  strobes_t        st;
  logic [OP_W-1:0] opcode;

  accum_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .st     (st),
    .halted (halted)
  );

  accum_dpath u_dpath (
    .clk       (clk),
    .rst       (rst),
    .startAddr (startAddr),
    .st        (st),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .pc        (pcOut),
    .acc       (accOut),
    .ir        (irOut),
    .opcode    (opcode)
  );

  assign memRe = st.memRe;
  assign memWe = st.memWe;
endmodule

// File: tb/sim_accum_core.sv
module sim_accum_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] startAddr = 12'h000;
  logic [15:0] memRdata;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memRe, memWe, halted;
  logic [11:0] pcOut;
  logic [15:0] accOut, irOut;

  logic [15:0] mem [4096];
  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  accum_core u0 (
    .clk(clk), .rst(rst), .startAddr(startAddr), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memRe(memRe), .memWe(memWe),
    .halted(halted), .pcOut(pcOut), .accOut(accOut), .irOut(irOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic startAt(input logic [11:0] s);
    @(negedge clk);
    rst = 1'b1;
    startAddr = s;
    @(negedge clk);
    chk("R7 reset pc", pcOut, s);
    chk("R7 reset acc", accOut, 16'h0);
    chk("R7 reset ir", irOut, 16'h0);
    chk("R7 reset halted", halted, 1'b0);
    chk("R7 reset no access", {memRe, memWe}, 2'b00);
    rst = 1'b0;
  endtask

  task automatic testExample();
    clearMem();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2941;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    startAt(12'h300);
    step(1);
    chk("R1 fetch read", memRe, 1'b1);
    chk("R1 fetch addr", memAddr, 12'h300);
    step(2);
    chk("R1 ir load", irOut, 16'h1940);
    step(3);
    chk("R2 load acc", accOut, 16'h0003);
    chk("R5 pc held during exec", pcOut, 12'h300);
    step(1);
    chk("R8 pc step 1", pcOut, 12'h301);
    step(6);
    chk("R4 add acc", accOut, 16'h0005);
    step(1);
    chk("R8 pc step 2", pcOut, 12'h302);
    step(4);
    chk("R3 store we", memWe, 1'b1);
    chk("R3 store addr", memAddr, 12'h941);
    chk("R3 store data", memWdata, 16'h0005);
    step(1);
    chk("R3 store single", memWe, 1'b0);
    chk("R5 pc held after write", pcOut, 12'h302);
    step(1);
    chk("R8 pc step 3", pcOut, 12'h303);
    chk("R8 mem 941", mem[12'h941], 16'h0005);
    chk("R8 acc", accOut, 16'h0005);
    step(4);
    chk("R6 halt on zero", halted, 1'b1);
  endtask

  task automatic testAddWrap();
    clearMem();
    mem[12'h010] = 16'h1100; mem[12'h011] = 16'h5101;
    mem[12'h100] = 16'hFFFF; mem[12'h101] = 16'h0003;
    startAt(12'h010);
    step(14);
    chk("R4 wrap sum", accOut, 16'h0002);
    chk("R5 pc after two", pcOut, 12'h012);
    step(3);
    chk("R6 not yet halted", halted, 1'b0);
    step(1);
    chk("R6 halted opcode 0", halted, 1'b1);
    chk("R6 pc held", pcOut, 12'h012);
  endtask

  task automatic testBadOpcode();
    clearMem();
    mem[12'h020] = 16'h1100; mem[12'h021] = 16'hF123;
    mem[12'h100] = 16'hABCD;
    startAt(12'h020);
    step(11);
    chk("R6 halted unassigned", halted, 1'b1);
    chk("R6 acc kept", accOut, 16'hABCD);
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R6 quiet while halted", {memRe, memWe}, 2'b00);
    end
    chk("R6 pc frozen", pcOut, 12'h021);
    chk("R6 still halted", halted, 1'b1);
    chk("R6 acc frozen", accOut, 16'hABCD);
  endtask

  task automatic testPcWrap();
    clearMem();
    mem[12'hFFF] = 16'h1030; mem[12'h030] = 16'h1234;
    startAt(12'hFFF);
    step(7);
    chk("R5 pc wrap", pcOut, 12'h000);
    chk("R2 load after wrap", accOut, 16'h1234);
    step(4);
    chk("R6 halt at 0", halted, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    step(2);
    testExample();
    testAddWrap();
    testBadOpcode();
    testPcWrap();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule